// File: doc/BRIEF.md
# Serial ATA Port Error Status Register

This block holds the sticky error status of one serial ATA port. Single-cycle event strobes arrive from the bus master and slave interfaces, the transport layer, the link layer, the receive FIFO and the CRC and handshake checkers. The block also watches the PHY ready level. Each strobe sets its error bit, and the bit stays set until software clears it by writing a one to it. Integrity faults are sorted by frame context. A fault during a data frame goes to the transient bit. A fault during any other frame goes to the recovered bit. A fault with no frame in flight goes to neither.

PHY ready transitions are filtered by power-management context. The block records the commanded power state (active, partial or slumber). After each commanded change it opens a window of `PM_WIN` cycles. Inside that window, a PHY ready drop that follows entry into a low-power state does not count as an error. Likewise, a PHY ready rise that follows a return to active does not count. The first PHY ready rise after reset is the interface initialization and is never flagged.

The register is read on `rd_data` at all times. A write strobe with a data word clears every bit whose position holds a one in that word.

Top module: `sata_err_status`

## Requirements
- R1: Bit 11 sets one cycle after `bus_err_mst` or `bus_err_slv` is high on a clock edge.
- R2: Bit 10 sets one cycle after any of `xport_state_err`, `link_seq_err`, `rx_fifo_ovf` or `link_bad_end` is high.
- R3: Bit 9 sets when `phy_rdy` falls, unless the fall is exempt. A fall is exempt when it is sampled on the k-th clock edge after the edge that sampled a `pm_cmd` moving the port from active (code 0) to partial (code 1) or slumber (code 2), with 1 <= k <= `PM_WIN`.
- R4: Bit 1 sets when `phy_rdy` rises, with two exceptions. The first rise since reset never sets it. A rise sampled on the k-th edge (1 <= k <= `PM_WIN`) after a `pm_cmd` moving the port from partial or slumber to active (code 0) does not set it either.
- R5: A fault is any R2 event, `crc_err`, `hshake_err`, or a non-exempt R3 drop. Bit 8 sets on a fault while `frame_busy` and `frame_is_data` are both high.
- R6: Bit 0 sets on a fault while `frame_busy` is high and `frame_is_data` is low. With `frame_busy` low, a fault sets neither bit 0 nor bit 8.
- R7: `crc_err` sets the diagnostic bit 17, and `hshake_err` sets the diagnostic bit 16.
- R8: Only bits 0, 1, 8, 9, 10, 11, 16 and 17 can ever read as one. All other bits, including 2 to 7, read zero.
- R9: A set bit stays set until a cycle with `wr_en` high and a one at its position in `wr_data` clears it. A zero at that position has no effect.
- R10: When a set event and a clear hit the same bit in the same cycle, the bit is set afterwards.
- R11: After reset, `rd_data` is zero, the port is active, no window is open and no PHY ready rise has been seen.
- R12: Some `pm_cmd` targets open no window: the current state again, a move between partial and slumber, and code 3. Code 3 also leaves the recorded state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_err_mst | input | 1 | Error response seen on the bus master side |
| bus_err_slv | input | 1 | Error response seen on the bus slave side |
| xport_state_err | input | 1 | Transport state-transition error strobe |
| link_seq_err | input | 1 | Link sequence error strobe |
| rx_fifo_ovf | input | 1 | Receive FIFO overflow strobe |
| link_bad_end | input | 1 | Frame closed by a terminate primitive instead of end-of-frame |
| crc_err | input | 1 | CRC error strobe |
| hshake_err | input | 1 | Handshake error strobe |
| phy_rdy | input | 1 | PHY ready level, synchronous to clk |
| pm_cmd | input | 1 | Power-state command strobe |
| pm_target | input | 2 | Commanded state: 0 active, 1 partial, 2 slumber, 3 ignored |
| frame_busy | input | 1 | A frame is being transferred |
| frame_is_data | input | 1 | The frame in flight is a data frame |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_data | input | 32 | Clear mask |
| rd_data | output | 32 | Error status register |

## Verification
The event strobes are swept over all 256 combinations, each under the three frame contexts (idle, non-data, data). This separates the bus, protocol and diagnostic bits, and it shows whether integrity faults reach the transient bit, the recovered bit or neither. PHY ready drops and rises are placed at every offset from one to `PM_WIN`+2 cycles after entry and exit commands. This pins down both window edges and shows whether the exemption is tied to the right direction. Separate patterns cover the uncounted first rise, a command that opens no window, a link loss inside a data frame, and a clear that coincides with a set.

// File: rtl/sata_err_pkg.sv
package sata_err_pkg;
  localparam int REG_W = 32;

  localparam int B_REC_INTEG  = 0;
  localparam int B_REC_COMM   = 1;
  localparam int B_TRN_INTEG  = 8;
  localparam int B_PERS_COMM  = 9;
  localparam int B_PROTO      = 10;
  localparam int B_INTERNAL   = 11;
  localparam int B_DIAG_HS    = 16;
  localparam int B_DIAG_CRC   = 17;

  localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << B_REC_INTEG) | (REG_W'(1) << B_REC_COMM) |
      (REG_W'(1) << B_TRN_INTEG) | (REG_W'(1) << B_PERS_COMM) |
      (REG_W'(1) << B_PROTO)     | (REG_W'(1) << B_INTERNAL) |
      (REG_W'(1) << B_DIAG_HS)   | (REG_W'(1) << B_DIAG_CRC);

  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'd0,
    PM_PARTIAL = 2'd1,
    PM_SLUMBER = 2'd2,
    PM_NONE    = 2'd3
  } pm_state_t;
endpackage

// File: rtl/sata_err_pm_filter.sv
module sata_err_pm_filter
  import sata_err_pkg::*;
#(
  parameter int PM_WIN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phy_rdy,
  input  logic       pm_cmd,
  input  logic [1:0] pm_target,
  output logic       comm_lost,
  output logic       comm_regained
);
  localparam int CNT_W = $clog2(PM_WIN + 1);

  pm_state_t        cur_st;
  logic [CNT_W-1:0] win_cnt;
  logic             win_entry;
  logic             rdy_q;
  logic             seen_rise;

  logic in_win, fall, rise, tgt_ok, go_low, go_active;

  always_comb begin
    in_win    = (win_cnt != '0);
    fall      = rdy_q & ~phy_rdy;
    rise      = ~rdy_q & phy_rdy;
    tgt_ok    = (pm_target != PM_NONE);
    go_low    = pm_cmd && tgt_ok && (cur_st == PM_ACTIVE) &&
                (pm_target != PM_ACTIVE);
    go_active = pm_cmd && tgt_ok && (cur_st != PM_ACTIVE) &&
                (pm_target == PM_ACTIVE);
    comm_lost     = fall & ~(in_win & win_entry);
    comm_regained = rise & seen_rise & ~(in_win & ~win_entry);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_st    <= PM_ACTIVE;
      win_cnt   <= '0;
      win_entry <= 1'b0;
      rdy_q     <= 1'b0;
      seen_rise <= 1'b0;
    end else begin
      rdy_q     <= phy_rdy;
      seen_rise <= seen_rise | rise;
      if (pm_cmd && tgt_ok) cur_st <= pm_state_t'(pm_target);
      if (go_low || go_active) begin
        win_cnt   <= CNT_W'(PM_WIN);
        win_entry <= go_low;
      end else if (in_win) begin
        win_cnt <= win_cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sata_err_classify.sv
module sata_err_classify
  import sata_err_pkg::*;
(
  input  logic             bus_err_mst,
  input  logic             bus_err_slv,
  input  logic             xport_state_err,
  input  logic             link_seq_err,
  input  logic             rx_fifo_ovf,
  input  logic             link_bad_end,
  input  logic             crc_err,
  input  logic             hshake_err,
  input  logic             comm_lost,
  input  logic             comm_regained,
  input  logic             frame_busy,
  input  logic             frame_is_data,
  output logic [REG_W-1:0] set_vec
);
  logic proto, fault;

  always_comb begin
    proto = xport_state_err | link_seq_err | rx_fifo_ovf | link_bad_end;
    fault = proto | crc_err | hshake_err | comm_lost;
    set_vec = '0;
    set_vec[B_INTERNAL]  = bus_err_mst | bus_err_slv;
    set_vec[B_PROTO]     = proto;
    set_vec[B_PERS_COMM] = comm_lost;
    set_vec[B_REC_COMM]  = comm_regained;
    set_vec[B_TRN_INTEG] = fault & frame_busy & frame_is_data;
    set_vec[B_REC_INTEG] = fault & frame_busy & ~frame_is_data;
    set_vec[B_DIAG_CRC]  = crc_err;
    set_vec[B_DIAG_HS]   = hshake_err;
  end
endmodule

// File: rtl/sata_err_sticky.sv
module sata_err_sticky #(
  parameter int            W    = 32,
  parameter logic [W-1:0]  MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] clr;

  always_comb clr = wr_en ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (set_vec | (q & ~clr)) & MASK;
  end
endmodule

// File: rtl/sata_err_status.sv
module sata_err_status
  import sata_err_pkg::*;
#(
  parameter int PM_WIN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_err_mst,
  input  logic        bus_err_slv,
  input  logic        xport_state_err,
  input  logic        link_seq_err,
  input  logic        rx_fifo_ovf,
  input  logic        link_bad_end,
  input  logic        crc_err,
  input  logic        hshake_err,
  input  logic        phy_rdy,
  input  logic        pm_cmd,
  input  logic [1:0]  pm_target,
  input  logic        frame_busy,
  input  logic        frame_is_data,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  logic             comm_lost, comm_regained;
  logic [REG_W-1:0] set_vec;

  sata_err_pm_filter #(.PM_WIN(PM_WIN)) u_pm (
    .clk(clk), .rst_n(rst_n), .phy_rdy(phy_rdy), .pm_cmd(pm_cmd),
    .pm_target(pm_target), .comm_lost(comm_lost),
    .comm_regained(comm_regained)
  );

  sata_err_classify u_cls (
    .bus_err_mst(bus_err_mst), .bus_err_slv(bus_err_slv),
    .xport_state_err(xport_state_err), .link_seq_err(link_seq_err),
    .rx_fifo_ovf(rx_fifo_ovf), .link_bad_end(link_bad_end),
    .crc_err(crc_err), .hshake_err(hshake_err),
    .comm_lost(comm_lost), .comm_regained(comm_regained),
    .frame_busy(frame_busy), .frame_is_data(frame_is_data),
    .set_vec(set_vec)
  );

  sata_err_sticky #(.W(REG_W), .MASK(IMPL_MASK)) u_reg (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr_en(wr_en),
    .wr_data(wr_data), .q(rd_data)
  );
endmodule

// File: rtl/sata_err_status_chk.sv
module sata_err_status_chk
  import sata_err_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_err_mst,
  input logic        bus_err_slv,
  input logic        xport_state_err,
  input logic        link_seq_err,
  input logic        rx_fifo_ovf,
  input logic        link_bad_end,
  input logic        crc_err,
  input logic        hshake_err,
  input logic        frame_busy,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data
);
  // R1
  bus_err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err_mst || bus_err_slv) |=> rd_data[B_INTERNAL]);

  // R2
  proto_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xport_state_err || link_seq_err || rx_fifo_ovf || link_bad_end)
      |=> rd_data[B_PROTO]);

  // R6
  idle_no_integ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_busy && !rd_data[B_REC_INTEG] && !rd_data[B_TRN_INTEG])
      |=> (!rd_data[B_REC_INTEG] && !rd_data[B_TRN_INTEG]));

  // R7
  diag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err || hshake_err)
      |=> (rd_data[B_DIAG_CRC] || rd_data[B_DIAG_HS]));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~IMPL_MASK) == '0);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[B_INTERNAL] && !(wr_en && wr_data[B_INTERNAL]))
      |=> rd_data[B_INTERNAL]);

  // R9
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_PROTO] && !xport_state_err && !link_seq_err &&
     !rx_fifo_ovf && !link_bad_end) |=> !rd_data[B_PROTO]);

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err_mst && wr_en && wr_data[B_INTERNAL]) |=> rd_data[B_INTERNAL]);
endmodule

bind sata_err_status sata_err_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_err_mst(bus_err_mst),
  .bus_err_slv(bus_err_slv), .xport_state_err(xport_state_err),
  .link_seq_err(link_seq_err), .rx_fifo_ovf(rx_fifo_ovf),
  .link_bad_end(link_bad_end), .crc_err(crc_err), .hshake_err(hshake_err),
  .frame_busy(frame_busy), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data)
);

// File: tb/sata_err_status_bench.sv
module sata_err_status_bench;
  localparam int WIN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ev = '0;
  logic        phy_rdy = 1'b0;
  logic        pm_cmd = 1'b0;
  logic [1:0]  pm_target = 2'd0;
  logic        frame_busy = 1'b0;
  logic        frame_is_data = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sata_err_status #(.PM_WIN(WIN)) u_sata_err_status (
    .clk(clk), .rst_n(rst_n),
    .bus_err_mst(ev[0]), .bus_err_slv(ev[1]),
    .xport_state_err(ev[2]), .link_seq_err(ev[3]),
    .rx_fifo_ovf(ev[4]), .link_bad_end(ev[5]),
    .crc_err(ev[6]), .hshake_err(ev[7]),
    .phy_rdy(phy_rdy), .pm_cmd(pm_cmd), .pm_target(pm_target),
    .frame_busy(frame_busy), .frame_is_data(frame_is_data),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%08h expected %08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_data = '1;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cmd(logic [1:0] t);
    pm_cmd = 1'b1; pm_target = t;
    tick();
    pm_cmd = 1'b0;
  endtask

  function automatic logic [31:0] model(logic [7:0] v, logic busy, logic dat);
    logic [31:0] e = '0;
    logic proto, fault;
    proto = |v[5:2];
    fault = proto | v[6] | v[7];
    e[11] = v[0] | v[1];
    e[10] = proto;
    e[17] = v[6];
    e[16] = v[7];
    e[8]  = fault & busy & dat;
    e[0]  = fault & busy & ~dat;
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: rd_data=%08h expected finish", rd_data);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    check("R11 reset", rd_data, 32'h0);

    // R4 first rise since reset is initialization
    phy_rdy = 1'b1;
    tick();
    check("R4 first rise", rd_data, 32'h0);

    // R3 / R4 window boundaries
    for (int k = 1; k <= WIN + 2; k++) begin
      clear_all();
      cmd(2'd1);
      repeat (k - 1) tick();
      phy_rdy = 1'b0;
      tick();
      check("R3 entry window", rd_data, (k > WIN) ? 32'h200 : 32'h0);
      repeat (WIN + 2) tick();
      clear_all();
      cmd(2'd0);
      repeat (k - 1) tick();
      phy_rdy = 1'b1;
      tick();
      check("R4 exit window", rd_data, (k > WIN) ? 32'h2 : 32'h0);
      repeat (WIN + 2) tick();
    end

    // R12 same-state command opens no window
    clear_all();
    cmd(2'd0);
    phy_rdy = 1'b0;
    tick();
    check("R12 same state", rd_data, 32'h200);
    phy_rdy = 1'b1;
    tick();
    check("R4 later rise", rd_data, 32'h202);

    // R12 partial->slumber opens no window; slumber->active still exempts
    clear_all();
    cmd(2'd1);
    phy_rdy = 1'b0;
    repeat (WIN + 2) tick();
    cmd(2'd2);
    repeat (WIN + 2) tick();
    cmd(2'd0);
    phy_rdy = 1'b1;
    tick();
    check("R12 slumber exit", rd_data, 32'h0);
    repeat (WIN + 2) tick();

    // R12 code 3 ignored: state stays active, no window
    clear_all();
    cmd(2'd3);
    phy_rdy = 1'b0;
    tick();
    check("R12 code3", rd_data, 32'h200);
    phy_rdy = 1'b1;
    tick();
    clear_all();

    // R5 link loss during data frame
    frame_busy = 1'b1; frame_is_data = 1'b1;
    phy_rdy = 1'b0;
    tick();
    frame_busy = 1'b0; frame_is_data = 1'b0;
    check("R5 loss in data frame", rd_data, 32'h300);
    phy_rdy = 1'b1;
    tick();
    clear_all();

    // R6 link loss during non-data frame
    frame_busy = 1'b1;
    phy_rdy = 1'b0;
    tick();
    frame_busy = 1'b0;
    check("R6 loss in non-data frame", rd_data, 32'h201);
    phy_rdy = 1'b1;
    tick();
    clear_all();

    // R1/R2/R5/R6/R7/R8 sweep of every strobe combination and frame context
    for (int p = 0; p < 1024; p++) begin
      logic [7:0] v;
      logic b, d;
      v = p[7:0];
      b = p[8];
      d = p[9];
      ev = v; frame_busy = b; frame_is_data = d;
      tick();
      ev = '0; frame_busy = 1'b0; frame_is_data = 1'b0;
      check("R1/R2/R5/R6/R7/R8 sweep", rd_data, model(v, b, d));
      clear_all();
    end

    // R9 write one clears only that bit, write zero holds
    ev = 8'h05;
    tick();
    ev = '0;
    wr_en = 1'b1; wr_data = 32'h800;
    tick();
    check("R9 w1c", rd_data, 32'h400);
    wr_data = 32'h0;
    tick();
    check("R9 write zero", rd_data, 32'h400);
    wr_data = 32'hFFFC_F0FC;
    tick();
    wr_en = 1'b0; wr_data = '0;
    check("R8 R9 unused writes", rd_data, 32'h400);

    // R10 set beats clear in same cycle
    ev = 8'h01;
    wr_en = 1'b1; wr_data = 32'h800;
    tick();
    ev = '0; wr_en = 1'b0; wr_data = '0;
    check("R10 set wins", rd_data, 32'hC00);
    tick();
    check("R9 held", rd_data, 32'hC00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule